// File: doc/BRIEF.md
# Mailbox-Commanded Input Counter Bank

This block is the device-side command engine of an isolated digital I/O card. The host talks to it over a byte-wide register bus: it writes operand bytes and a command byte into an outgoing mailbox, then polls an incoming mailbox until the command byte comes back. The engine drives eight relay outputs and reports the state of the relays and the inputs. It also runs eight 16-bit up-counters, each counting edges on one of eight digital inputs.

All configuration of the counters goes through commands: enable masks, edge selection, reload values, match values, and the overflow and match interrupt enables. Each counter keeps a sticky overflow flag and a sticky match flag. Every flag whose enable is set feeds one OR-ed interrupt request line.

Bus map: a write to offset 0 stores the low operand byte and a write to offset 1 stores the high operand byte. A write to offset 2 issues a command using the stored operands. A write to offset 3 is discarded. Reads return the incoming byte selected by `bus_addr`: 0 low result, 1 high result, 2 completion echo, 3 input snapshot.

Top module: `mbox_cnt_bank`

## Requirements
- R1: After reset, `relay_out` is 0x00, `irq` is 0 and all four incoming bytes read 0x00.
- R2: A write to offset 2 while idle is accepted. The incoming byte 2 takes the command code on the 4th rising edge after the accepting edge and holds it until the next completion. A write to offset 2 during those 4 cycles is ignored.
- R3: Command 0x00 sets incoming byte 2 to 0x00 and puts the synchronised 8-bit input state in incoming byte 3.
- R4: Command 0x01 drives `relay_out` from the low operand, and only that command changes it. Command 0x02 copies the relay state to incoming byte 0.
- R5: Command 0x28 enables counter i when bit i of the low operand is 1 and disables it otherwise. A disabled counter holds its value.
- R6: Command 0x2c selects the count edge per input: a bit of 0 counts rising edges and a bit of 1 counts falling edges. Each input passes two synchroniser flops before edge detection.
- R7: Command 0x2f returns the counter selected by low operand bits [2:0]: bits 7:0 in incoming byte 0 and bits 15:8 in incoming byte 1.
- R8: Commands 0x40+n set counter n's reload value from high:low operand (n = 0..7). Command 0x29 loads every counter selected in the low operand mask with its reload value and clears that counter's overflow and match flags.
- R9: Commands 0x48+n set counter n's match value. A count step that reaches the match value sets the sticky match flag. Command 0x2b sets the match interrupt enables.
- R10: An enabled counter steps by one per selected edge and wraps from 0xFFFF to 0x0000, which sets its sticky overflow flag. Command 0x2a sets the overflow interrupt enables. `irq` is the OR of every enabled flag.
- R11: An unknown command code is echoed in incoming byte 2 and changes no relay, counter, configuration or other incoming byte.
- R12: After reset all counters are disabled and hold 0x0000, count on rising edges, have reload value 0x0000 and match value 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Byte offset for writes and reads |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Incoming mailbox byte selected by `bus_addr` |
| din | input | 8 | Asynchronous digital inputs that feed the counters |
| relay_out | output | 8 | Relay drive outputs |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- The completion byte changes only one cycle after an execute strobe, and then to the executed code.
- An execute strobe falls only inside a busy window.
- The relays change only on a relay-set command.
- A counter changes only when it is enabled or loaded.
- An overflow flag rises only after a count of 0xFFFF.
- The request line is never raised without a flag.

Only the bench's scenarios can show the values behind these events: which edge polarity counts, the result bytes of a readout, the reload and match values, the exact four-cycle echo latency, that a command issued while busy is dropped, and that an unknown code is inert.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  localparam int CNT_W = 16;

  localparam logic [7:0] CMD_CLEAR     = 8'h00;
  localparam logic [7:0] CMD_RELAY_SET = 8'h01;
  localparam logic [7:0] CMD_RELAY_GET = 8'h02;
  localparam logic [7:0] CMD_CNT_EN    = 8'h28;
  localparam logic [7:0] CMD_CNT_LOAD  = 8'h29;
  localparam logic [7:0] CMD_OVF_IE    = 8'h2a;
  localparam logic [7:0] CMD_MAT_IE    = 8'h2b;
  localparam logic [7:0] CMD_EDGE      = 8'h2c;
  localparam logic [7:0] CMD_CNT_GET   = 8'h2f;
  localparam logic [7:0] CMD_RSTV_BASE = 8'h40;
  localparam logic [7:0] CMD_MATV_BASE = 8'h48;

  // edge detect on synchronised sample (cur) and its previous value (old)
  function automatic logic edge_hit(input logic cur, input logic old, input logic fall);
    return fall ? (old & ~cur) : (cur & ~old);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_inc(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/mbc_sync.sv
module mbc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] fall_sel,
  output logic [W-1:0] din_s,
  output logic [W-1:0] hit
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign din_s = s2;

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign hit[i] = mbc_pkg::edge_hit(s2[i], s3[i], fall_sel[i]);
  end
endmodule

// File: rtl/mbc_lane.sv
module mbc_lane
  import mbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hit,
  input  logic             load,
  input  logic             rv_wr,
  input  logic             mv_wr,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             mat
);
  localparam logic [CNT_W-1:0] MATCH_INIT = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] rstv, matv, cnt_nx;
  logic             step;

  assign step   = en & hit;
  assign cnt_nx = cnt_inc(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rstv <= '0;
      matv <= MATCH_INIT;
      ovf  <= 1'b0;
      mat  <= 1'b0;
    end else begin
      if (rv_wr) rstv <= wval;
      if (mv_wr) matv <= wval;
      if (load) begin
        cnt <= rstv;
        ovf <= 1'b0;
        mat <= 1'b0;
      end else if (step) begin
        cnt <= cnt_nx;
        if (cnt == '1) ovf <= 1'b1;
        if (cnt_nx == matv) mat <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
#(
  parameter int N        = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic [7:0]             bus_wdata,
  input  logic [N-1:0]           din_s,
  input  logic [N-1:0][CNT_W-1:0] cnt_all,
  output logic [7:0]             bus_rdata,
  output logic [7:0]             relay_out,
  output logic [N-1:0]           en_mask,
  output logic [N-1:0]           fall_mask,
  output logic [N-1:0]           ovf_ie,
  output logic [N-1:0]           mat_ie,
  output logic [N-1:0]           load_mask,
  output logic [N-1:0]           rv_wr,
  output logic [N-1:0]           mv_wr,
  output logic [CNT_W-1:0]       wval,
  output logic                   accept,
  output logic                   busy,
  output logic                   exec_stb,
  output logic [7:0]             exec_cmd,
  output logic [7:0]             imb2
);
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;
  localparam int WAIT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

  logic [7:0]        omb_lo, omb_hi, cmd_q, op_lo, op_hi;
  logic [7:0]        imb0, imb1, imb3;
  logic [WAIT_W-1:0] wait_q;
  logic              busy_q;
  logic [IDX_W-1:0]  sel;

  assign busy     = busy_q;
  assign exec_stb = busy_q && (wait_q == '0);
  assign accept   = bus_wr && (bus_addr == 2'd2) && !busy_q;
  assign exec_cmd = cmd_q;
  assign wval     = {op_hi, op_lo};
  assign sel      = op_lo[IDX_W-1:0];
  assign load_mask = (exec_stb && cmd_q == CMD_CNT_LOAD) ? op_lo[N-1:0] : '0;

  for (genvar i = 0; i < N; i++) begin : g_wr
    assign rv_wr[i] = exec_stb && (cmd_q == (CMD_RSTV_BASE + 8'(i)));
    assign mv_wr[i] = exec_stb && (cmd_q == (CMD_MATV_BASE + 8'(i)));
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = imb0;
      2'd1:    bus_rdata = imb1;
      2'd2:    bus_rdata = imb2;
      default: bus_rdata = imb3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      omb_lo <= '0; omb_hi <= '0;
      cmd_q  <= '0; op_lo  <= '0; op_hi <= '0;
      wait_q <= '0; busy_q <= 1'b0;
      imb0 <= '0; imb1 <= '0; imb2 <= '0; imb3 <= '0;
      relay_out <= '0;
      en_mask <= '0; fall_mask <= '0; ovf_ie <= '0; mat_ie <= '0;
    end else begin
      if (bus_wr && bus_addr == 2'd0) omb_lo <= bus_wdata;
      if (bus_wr && bus_addr == 2'd1) omb_hi <= bus_wdata;

      if (accept) begin
        busy_q <= 1'b1;
        wait_q <= WAIT_W'(BUSY_CYC - 1);
        cmd_q  <= bus_wdata;
        op_lo  <= omb_lo;
        op_hi  <= omb_hi;
      end else if (exec_stb) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        wait_q <= wait_q - 1'b1;
      end

      if (exec_stb) begin
        imb2 <= cmd_q;
        case (cmd_q)
          CMD_CLEAR:     imb3 <= 8'(din_s);
          CMD_RELAY_SET: relay_out <= op_lo;
          CMD_RELAY_GET: imb0 <= relay_out;
          CMD_CNT_EN:    en_mask <= op_lo[N-1:0];
          CMD_OVF_IE:    ovf_ie <= op_lo[N-1:0];
          CMD_MAT_IE:    mat_ie <= op_lo[N-1:0];
          CMD_EDGE:      fall_mask <= op_lo[N-1:0];
          CMD_CNT_GET: begin
            imb0 <= cnt_all[sel][7:0];
            imb1 <= cnt_all[sel][15:8];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbox_cnt_bank.sv
module mbox_cnt_bank
  import mbc_pkg::*;
#(
  parameter int N_LANES  = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [N_LANES-1:0] din,
  output logic [7:0]         relay_out,
  output logic               irq
);
  logic [N_LANES-1:0]            din_s, hit, en_mask, fall_mask, ovf_ie, mat_ie;
  logic [N_LANES-1:0]            load_mask, rv_wr, mv_wr, ovf, mat;
  logic [N_LANES-1:0][CNT_W-1:0] cnt_all;
  logic [CNT_W-1:0]              wval;
  logic                          accept, busy, exec_stb;
  logic [7:0]                    exec_cmd, imb2;

  mbc_sync #(.W(N_LANES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(din), .fall_sel(fall_mask),
    .din_s(din_s), .hit(hit)
  );

  mbc_ctrl #(.N(N_LANES), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .din_s(din_s), .cnt_all(cnt_all),
    .bus_rdata(bus_rdata), .relay_out(relay_out), .en_mask(en_mask),
    .fall_mask(fall_mask), .ovf_ie(ovf_ie), .mat_ie(mat_ie),
    .load_mask(load_mask), .rv_wr(rv_wr), .mv_wr(mv_wr), .wval(wval),
    .accept(accept), .busy(busy), .exec_stb(exec_stb),
    .exec_cmd(exec_cmd), .imb2(imb2)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    mbc_lane u_lane (
      .clk(clk), .rst_n(rst_n), .en(en_mask[i]), .hit(hit[i]),
      .load(load_mask[i]), .rv_wr(rv_wr[i]), .mv_wr(mv_wr[i]),
      .wval(wval), .cnt(cnt_all[i]), .ovf(ovf[i]), .mat(mat[i])
    );
  end

  assign irq = |((ovf & ovf_ie) | (mat & mat_ie));
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker
  import mbc_pkg::*;
#(
  parameter int N = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   accept,
  input logic                   busy,
  input logic                   exec_stb,
  input logic [7:0]             exec_cmd,
  input logic [7:0]             imb2,
  input logic [7:0]             relay_out,
  input logic                   irq,
  input logic [N-1:0][CNT_W-1:0] cnt_all,
  input logic [N-1:0]           ovf,
  input logic [N-1:0]           mat,
  input logic [N-1:0]           en_mask,
  input logic [N-1:0]           load_mask
);
  p_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> (imb2 == $past(exec_cmd)));

  p_imb2_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(imb2) |-> $past(exec_stb));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_exec_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> busy);

  p_relay_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(relay_out) |-> $past(exec_stb && exec_cmd == CMD_RELAY_SET));

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(ovf | mat)));

  for (genvar i = 0; i < N; i++) begin : g_lane_chk
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_all[i]) |-> $past(en_mask[i] | load_mask[i]));

    p_ovf_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[i]) |-> ($past(cnt_all[i]) == '1));
  end
endmodule

bind mbox_cnt_bank mbc_checker #(.N(N_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
  .exec_stb(exec_stb), .exec_cmd(exec_cmd), .imb2(imb2),
  .relay_out(relay_out), .irq(irq), .cnt_all(cnt_all), .ovf(ovf),
  .mat(mat), .en_mask(en_mask), .load_mask(load_mask)
);

// File: tb/tb_mbox_cnt_bank.sv
`timescale 1ns/1ps
module tb_mbox_cnt_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] din = 8'h00;
  logic [7:0] relay_out;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbox_cnt_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din),
    .relay_out(relay_out), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_cnt [8];
  logic [15:0] m_rstv [8];
  logic [15:0] m_matv [8];
  logic [7:0]  m_en, m_fall, m_oie, m_mie, m_ovf, m_mat, m_relay;
  logic [7:0]  m_imb [4];
  logic [7:0]  m_omb0, m_omb1, m_cmd, m_op0, m_op1;
  logic [7:0]  m_p1, m_p2, m_p3;
  int          m_wait;
  bit          m_busy;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_cnt[i] = 16'h0; m_rstv[i] = 16'h0; m_matv[i] = 16'h8000;
      end
      m_en = 0; m_fall = 0; m_oie = 0; m_mie = 0; m_ovf = 0; m_mat = 0;
      m_relay = 0; m_omb0 = 0; m_omb1 = 0; m_cmd = 0; m_op0 = 0; m_op1 = 0;
      for (int k = 0; k < 4; k++) m_imb[k] = 0;
      m_p1 = 0; m_p2 = 0; m_p3 = 0; m_wait = 0; m_busy = 0;
    end else begin
      bit go;
      bit acc;
      logic [7:0] ev;
      go = m_busy && (m_wait == 0);
      for (int i = 0; i < 8; i++)
        ev[i] = m_fall[i] ? (m_p3[i] && !m_p2[i]) : (m_p2[i] && !m_p3[i]);
      if (go) begin
        if (m_cmd == 8'h00) m_imb[3] = m_p2;
        if (m_cmd == 8'h02) m_imb[0] = m_relay;
        if (m_cmd == 8'h2f) begin
          m_imb[0] = m_cnt[m_op0 % 8][7:0];
          m_imb[1] = m_cnt[m_op0 % 8][15:8];
        end
        m_imb[2] = m_cmd;
      end
      for (int i = 0; i < 8; i++) begin
        if (go && m_cmd == 8'h29 && m_op0[i]) begin
          m_cnt[i] = m_rstv[i]; m_ovf[i] = 0; m_mat[i] = 0;
        end else if (m_en[i] && ev[i]) begin
          if (m_cnt[i] == 16'hFFFF) m_ovf[i] = 1;
          m_cnt[i] = m_cnt[i] + 16'd1;
          if (m_cnt[i] == m_matv[i]) m_mat[i] = 1;
        end
      end
      if (go) begin
        case (m_cmd)
          8'h01: m_relay = m_op0;
          8'h28: m_en = m_op0;
          8'h2a: m_oie = m_op0;
          8'h2b: m_mie = m_op0;
          8'h2c: m_fall = m_op0;
          default: begin
            if (m_cmd >= 8'h40 && m_cmd <= 8'h47) m_rstv[m_cmd - 8'h40] = {m_op1, m_op0};
            if (m_cmd >= 8'h48 && m_cmd <= 8'h4f) m_matv[m_cmd - 8'h48] = {m_op1, m_op0};
          end
        endcase
      end
      acc = bus_wr && bus_addr == 2'd2 && !m_busy;
      if (go) m_busy = 0;
      else if (m_busy) m_wait = m_wait - 1;
      if (acc) begin
        m_busy = 1; m_wait = 3; m_cmd = bus_wdata; m_op0 = m_omb0; m_op1 = m_omb1;
      end
      if (bus_wr && bus_addr == 2'd0) m_omb0 = bus_wdata;
      if (bus_wr && bus_addr == 2'd1) m_omb1 = bus_wdata;
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = din;
    end
  end

  // every-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (relay_out !== m_relay) begin
        errors++; $display("FAIL R4 model relay act=%h exp=%h", relay_out, m_relay);
      end
      checks++;
      if (irq !== (|((m_ovf & m_oie) | (m_mat & m_mie)))) begin
        errors++; $display("FAIL R10 model irq act=%b exp=%b", irq, |((m_ovf & m_oie) | (m_mat & m_mie)));
      end
      checks++;
      if (bus_rdata !== m_imb[bus_addr]) begin
        errors++; $display("FAIL R2 model mailbox byte %0d act=%h exp=%h", bus_addr, bus_rdata, m_imb[bus_addr]);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog expired act=%0d exp=<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic cmd(input logic [7:0] c, input logic [7:0] o0, input logic [7:0] o1);
    wr(2'd0, o0);
    wr(2'd1, o1);
    wr(2'd2, c);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(input int b);
    @(negedge clk); din[b] = 1'b1;
    repeat (4) @(negedge clk);
    din[b] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_cnt(input logic [7:0] idx, output logic [15:0] v);
    logic [7:0] lo, hi;
    cmd(8'h2f, idx, 8'h00);
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 relay after reset", 16'(relay_out), 16'h00);
    chk("R1 irq after reset", 16'(irq), 16'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), b);
      chk("R1 incoming byte after reset", 16'(b), 16'h00);
    end

    // R4 relay set and readback
    cmd(8'h02, 8'h00, 8'h00);
    rd(2'd0, b); chk("R4 relay readback default", 16'(b), 16'h00);
    cmd(8'h01, 8'hA5, 8'h00);
    chk("R4 relay driven", 16'(relay_out), 16'hA5);
    cmd(8'h02, 8'h00, 8'h00);
    rd(2'd0, b); chk("R4 relay readback", 16'(b), 16'hA5);

    // R2 echo latency
    wr(2'd0, 8'h3C);
    @(negedge clk); bus_addr = 2'd2; bus_wr = 1'b1; bus_wdata = 8'h01;
    @(negedge clk); bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R2 echo not before 4th edge", 16'(bus_rdata), 16'h02);
    @(negedge clk);
    #1 chk("R2 echo on 4th edge", 16'(bus_rdata), 16'h01);
    repeat (3) @(negedge clk);
    chk("R4 relay second value", 16'(relay_out), 16'h3C);

    // R2 command while busy is dropped
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h99);
    wr(2'd2, 8'h01);
    repeat (8) @(negedge clk);
    chk("R2 busy write ignored", 16'(relay_out), 16'h11);

    // R3 input snapshot
    din = 8'h5A;
    repeat (4) @(negedge clk);
    cmd(8'h00, 8'h00, 8'h00);
    rd(2'd2, b); chk("R3 echo cleared", 16'(b), 16'h00);
    rd(2'd3, b); chk("R3 input snapshot", 16'(b), 16'h5A);
    din = 8'h00;
    repeat (4) @(negedge clk);

    // R12 defaults, R5 enable, R6 rising edge
    read_cnt(8'h00, v); chk("R12 default count", v, 16'h0000);
    cmd(8'h28, 8'h01, 8'h00);
    repeat (3) pulse(0);
    repeat (2) pulse(1);
    read_cnt(8'h00, v); chk("R5 R6 R7 enabled rising count", v, 16'd3);
    read_cnt(8'h01, v); chk("R5 disabled counter holds", v, 16'd0);

    // R6 falling edge
    cmd(8'h2c, 8'h04, 8'h00);
    cmd(8'h28, 8'h05, 8'h00);
    @(negedge clk); din[2] = 1'b1;
    repeat (6) @(negedge clk);
    read_cnt(8'h02, v); chk("R6 falling mode ignores rise", v, 16'd0);
    din[2] = 1'b0;
    repeat (6) @(negedge clk);
    read_cnt(8'h02, v); chk("R6 falling mode counts fall", v, 16'd1);

    // R8 reload value, R7 byte placement
    cmd(8'h43, 8'h34, 8'h12);
    cmd(8'h29, 8'h08, 8'h00);
    cmd(8'h2f, 8'h03, 8'h00);
    rd(2'd0, b); chk("R7 low byte", 16'(b), 16'h34);
    rd(2'd1, b); chk("R7 R8 high byte", 16'(b), 16'h12);

    // R10 wrap, overflow flag, enable
    cmd(8'h45, 8'hFE, 8'hFF);
    cmd(8'h29, 8'h20, 8'h00);
    cmd(8'h28, 8'h25, 8'h00);
    repeat (2) pulse(5);
    chk("R10 flag masked", 16'(irq), 16'h0);
    read_cnt(8'h05, v); chk("R10 wrap to zero", v, 16'h0000);
    cmd(8'h2a, 8'h20, 8'h00);
    chk("R10 overflow irq", 16'(irq), 16'h1);
    cmd(8'h29, 8'h20, 8'h00);
    chk("R8 load clears flag", 16'(irq), 16'h0);
    read_cnt(8'h05, v); chk("R8 load value", v, 16'hFFFE);

    // R9 match
    cmd(8'h4e, 8'h02, 8'h00);
    cmd(8'h2b, 8'h40, 8'h00);
    cmd(8'h28, 8'hE5, 8'h00);
    pulse(6);
    chk("R9 below match", 16'(irq), 16'h0);
    pulse(6);
    chk("R9 match irq", 16'(irq), 16'h1);
    cmd(8'h2b, 8'h00, 8'h00);
    chk("R9 match ie off", 16'(irq), 16'h0);

    // R12 default reload value
    pulse(7);
    cmd(8'h29, 8'h80, 8'h00);
    read_cnt(8'h07, v); chk("R12 default reload", v, 16'h0000);

    // R11 unknown command
    cmd(8'h77, 8'h55, 8'h00);
    rd(2'd2, b); chk("R11 unknown echoed", 16'(b), 16'h77);
    rd(2'd0, b); chk("R11 result byte untouched", 16'(b), 16'h00);
    chk("R11 relay untouched", 16'(relay_out), 16'h11);
    read_cnt(8'h00, v); chk("R11 counter untouched", v, 16'd3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule